// File: doc/BRIEF.md
# Vector Register Tag Table

This block holds a sixteen-entry table of register tags. A scalar core uses it to decide whether an instruction should be repeated over vector elements. Software fills the table through eight 32-bit configuration CSRs. Each write places two 16-bit entries and zeroes every entry at a higher index. From the same write the block rebuilds two register-indexed lookup tables, one for integer registers and one for floating-point registers. The rebuild scans the entries from index 0 upward and stops at the first entry that is entirely zero.

A combinational lookup port takes a register class and a 5-bit register number. It returns whether that register is tagged as a vector, together with the target index, the element-width code and the packed flag of the tag. The block also holds the max-vector-length and vector-length CSRs, and clamps each value as it is written.

Top module: `vreg_tag_table`

## Requirements
- R1: A write to configuration CSR n (addresses 0..7) loads entry 2n from write bits 15:0 and entry 2n+1 from write bits 31:16.
- R2: The same write zeroes every entry with an index above 2n+1. Entries below 2n keep their contents.
- R3: The rebuild visits entries from index 0 upward and stops at the first entry whose 16 bits are all zero. Entries at or after that entry are ignored.
- R4: Entry layout: bit 0 is the class (1 integer, 0 floating point), bits 5:1 the register key, bits 7:6 the element-width code (0 8-bit, 1 default, 2 half, 3 double), bits 13:8 the target index, bit 14 the vector flag and bit 15 the packed flag. Each visited entry marks its keyed slot in its class's table as active and copies these fields into the slot.
- R5: lookup_vec_o is 1 only when the addressed slot is active and has its vector flag set. The other lookup outputs show the fields of that slot. When two visited entries share a class and key, the one with the higher index wins.
- R6: Every lookup slot is cleared before a rebuild, so slots that no visited entry names read back as all zero. The new table is visible from the cycle after the write.
- R7: A write to address 8 stores min(write data, 63) as the max vector length.
- R8: A write to address 9 stores min(write data, current max vector length) as the vector length.
- R9: Reads of addresses 0..7 return zero. Address 8 returns the max vector length and address 9 the vector length, both zero-extended. Every other address returns zero.
- R10: Reset clears all entries, both lookup tables and both length CSRs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 4 | CSR address (0..7 configuration, 8 max length, 9 length) |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for csr_addr_i |
| look_int_i | input | 1 | Lookup class, 1 integer, 0 floating point |
| look_reg_i | input | 5 | Lookup register number |
| look_vec_o | output | 1 | Register is tagged as a vector |
| look_tgt_o | output | 6 | Target index of the slot |
| look_ew_o | output | 2 | Element-width code of the slot |
| look_packed_o | output | 1 | Packed flag of the slot |
| mvl_o | output | 6 | Max vector length |
| vl_o | output | 6 | Vector length |

## Verification
The bench writes a configuration CSR above entries already in place. A design that skipped the wipe would keep reporting the upper tags. It places a zero entry ahead of valid ones, which a scan without the stop rule would wrongly pick up. It also repeats a key so that only the later entry should win; getting this wrong shows up as the target index of the earlier entry. Finally it lowers the max length below a value being written to the vector length, and a missing clamp then shows through the read port.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  localparam int KEY_W = 5;
  localparam int TGT_W = 6;
  localparam int EW_W  = 2;

  typedef struct packed {
    logic             packed_f;
    logic             vec_f;
    logic [TGT_W-1:0] tgt;
    logic [EW_W-1:0]  ew;
    logic [KEY_W-1:0] key;
    logic             is_int;
  } tag_entry_t;

  typedef struct packed {
    logic             active;
    logic             vec_f;
    logic             packed_f;
    logic [TGT_W-1:0] tgt;
    logic [EW_W-1:0]  ew;
  } slot_t;
endpackage

// File: rtl/vtag_entry_store.sv
module vtag_entry_store
  import vtag_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int NUM_CFG = NUM_ENTRIES / 2,
  localparam int SEL_W = $clog2(NUM_CFG)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic [31:0]                     wdata_i,
  output tag_entry_t [NUM_ENTRIES-1:0]    ent_d_o
);
  tag_entry_t [NUM_ENTRIES-1:0] ent_q;

  always_comb begin
    ent_d_o = ent_q;
    if (load_i) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (i / 2 == int'(sel_i))
          ent_d_o[i] = (i % 2 == 1) ? tag_entry_t'(wdata_i[31:16]) : tag_entry_t'(wdata_i[15:0]);
        else if (i / 2 > int'(sel_i))
          ent_d_o[i] = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= '0;
    else         ent_q <= ent_d_o;
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_wipe_chk
    // R2
    wipe_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && (g / 2 > int'(sel_i))) |=> (ent_q[g] == '0));
  end
endmodule

// File: rtl/vtag_rebuild.sv
module vtag_rebuild
  import vtag_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  tag_entry_t [NUM_ENTRIES-1:0] ent_i,
  input  logic                         look_int_i,
  input  logic [REG_W-1:0]             look_reg_i,
  output slot_t                        slot_o
);
  slot_t [NUM_REGS-1:0] int_q, fp_q, int_d, fp_d;
  logic  [NUM_REGS-1:0] int_act, fp_act;

  always_comb begin
    logic  alive;
    slot_t s;
    int_d = '0;
    fp_d  = '0;
    alive = 1'b1;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (ent_i[i] == '0) alive = 1'b0;
      s = '{active: 1'b1, vec_f: ent_i[i].vec_f, packed_f: ent_i[i].packed_f,
            tgt: ent_i[i].tgt, ew: ent_i[i].ew};
      if (alive) begin
        if (ent_i[i].is_int) int_d[ent_i[i].key] = s;
        else                 fp_d[ent_i[i].key]  = s;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= '0;
      fp_q  <= '0;
    end else if (load_i) begin
      int_q <= int_d;
      fp_q  <= fp_d;
    end
  end

  assign slot_o = look_int_i ? int_q[look_reg_i] : fp_q[look_reg_i];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_act
    assign int_act[g] = int_q[g].active;
    assign fp_act[g]  = fp_q[g].active;
  end

  // R3
  zero_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && ent_i[0] == '0) |=> (int_act == '0 && fp_act == '0));
endmodule

// File: rtl/vtag_len_csr.sv
module vtag_len_csr #(
  parameter int MVL_CAP = 63,
  localparam int LEN_W = $clog2(MVL_CAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mvl_we_i,
  input  logic             vl_we_i,
  input  logic [31:0]      wdata_i,
  output logic [LEN_W-1:0] mvl_o,
  output logic [LEN_W-1:0] vl_o
);
  localparam logic [31:0] CAP32 = 32'(MVL_CAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mvl_o <= '0;
      vl_o  <= '0;
    end else begin
      if (mvl_we_i) mvl_o <= (wdata_i > CAP32) ? LEN_W'(MVL_CAP) : wdata_i[LEN_W-1:0];
      if (vl_we_i)  vl_o  <= (wdata_i > 32'(mvl_o)) ? mvl_o : wdata_i[LEN_W-1:0];
    end
  end

  // R7
  mvl_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mvl_we_i |=> (32'(mvl_o) == $past(wdata_i) || ($past(wdata_i) > CAP32 && 32'(mvl_o) == CAP32)));
  // R8
  vl_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_we_i |=> (vl_o <= $past(mvl_o)));
endmodule

// File: rtl/vreg_tag_table.sv
module vreg_tag_table
  import vtag_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_REGS = 32,
  parameter int MVL_CAP = 63,
  parameter int CSR_AW = 4,
  localparam int NUM_CFG = NUM_ENTRIES / 2,
  localparam int SEL_W = $clog2(NUM_CFG),
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int LEN_W = $clog2(MVL_CAP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic [31:0]       csr_wdata_i,
  output logic [31:0]       csr_rdata_o,
  input  logic              look_int_i,
  input  logic [REG_W-1:0]  look_reg_i,
  output logic              look_vec_o,
  output logic [TGT_W-1:0]  look_tgt_o,
  output logic [EW_W-1:0]   look_ew_o,
  output logic              look_packed_o,
  output logic [LEN_W-1:0]  mvl_o,
  output logic [LEN_W-1:0]  vl_o
);
  localparam int MVL_ADDR = NUM_CFG;
  localparam int VL_ADDR  = NUM_CFG + 1;

  logic cfg_hit, cfg_we, mvl_we, vl_we;
  tag_entry_t [NUM_ENTRIES-1:0] ent_d;
  slot_t slot;

  assign cfg_hit = int'(csr_addr_i) < NUM_CFG;
  assign cfg_we  = csr_we_i && cfg_hit;
  assign mvl_we  = csr_we_i && int'(csr_addr_i) == MVL_ADDR;
  assign vl_we   = csr_we_i && int'(csr_addr_i) == VL_ADDR;

  vtag_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cfg_we),
    .sel_i(csr_addr_i[SEL_W-1:0]), .wdata_i(csr_wdata_i), .ent_d_o(ent_d)
  );

  vtag_rebuild #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_REGS(NUM_REGS)) u_rebuild (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cfg_we), .ent_i(ent_d),
    .look_int_i(look_int_i), .look_reg_i(look_reg_i), .slot_o(slot)
  );

  vtag_len_csr #(.MVL_CAP(MVL_CAP)) u_len (
    .clk_i(clk_i), .rst_ni(rst_ni), .mvl_we_i(mvl_we), .vl_we_i(vl_we),
    .wdata_i(csr_wdata_i), .mvl_o(mvl_o), .vl_o(vl_o)
  );

  assign look_vec_o    = slot.active & slot.vec_f;
  assign look_tgt_o    = slot.tgt;
  assign look_ew_o     = slot.ew;
  assign look_packed_o = slot.packed_f;

  always_comb begin
    csr_rdata_o = '0;
    if (int'(csr_addr_i) == MVL_ADDR)     csr_rdata_o = 32'(mvl_o);
    else if (int'(csr_addr_i) == VL_ADDR) csr_rdata_o = 32'(vl_o);
  end

  // R9
  cfg_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_hit |-> (csr_rdata_o == '0));
endmodule

// File: tb/vreg_tag_table_tb_top.sv
module vreg_tag_table_tb_top;
  logic        clk = 0, rst_ni = 0;
  logic        csr_we = 0;
  logic [3:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic        look_int = 0;
  logic [4:0]  look_reg = '0;
  logic        look_vec, look_packed;
  logic [5:0]  look_tgt, mvl, vl;
  logic [1:0]  look_ew;

  int checks = 0, errors = 0;
  logic [15:0] mdl [16];

  always #5 clk = ~clk;

  vreg_tag_table dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(csr_we), .csr_addr_i(csr_addr),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata), .look_int_i(look_int),
    .look_reg_i(look_reg), .look_vec_o(look_vec), .look_tgt_o(look_tgt),
    .look_ew_o(look_ew), .look_packed_o(look_packed), .mvl_o(mvl), .vl_o(vl)
  );

  // Entry layout per R4
  function automatic logic [15:0] mk(bit isint, int key, int ew, int tgt, bit vec, bit pk);
    return {pk, vec, 6'(tgt), 2'(ew), 5'(key), isint};
  endfunction

  // {vec, packed, tgt, ew} expected per R3..R6
  function automatic logic [9:0] exp_slot(bit isint, int r);
    logic [9:0] res = '0;
    for (int i = 0; i < 16; i++) begin
      if (mdl[i] == '0) break;
      if (mdl[i][0] == isint && int'(mdl[i][5:1]) == r)
        res = {mdl[i][14], mdl[i][15], mdl[i][13:8], mdl[i][7:6]};
    end
    return res;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csr_wr(int addr, logic [31:0] d);
    @(negedge clk);
    csr_we = 1; csr_addr = 4'(addr); csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic cfg_wr(int n, logic [15:0] lo, logic [15:0] hi);
    csr_wr(n, {hi, lo});
    mdl[2*n] = lo; mdl[2*n+1] = hi;
    for (int i = 2*n + 2; i < 16; i++) mdl[i] = '0;
  endtask

  task automatic sweep(string req);
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 32; r++) begin
        look_int = c[0]; look_reg = 5'(r); #1;
        chk(req, {22'b0, look_vec, look_packed, look_tgt, look_ew}, {22'b0, exp_slot(c[0], r)});
      end
  endtask

  task automatic rd(string req, int addr, logic [31:0] exp);
    csr_addr = 4'(addr); #1;
    chk(req, csr_rdata, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    sweep("R10 lookup after reset");
    chk("R10 mvl", 32'(mvl), 0);
    chk("R10 vl", 32'(vl), 0);
  endtask

  task automatic t_pair_load; // R1 R4
    cfg_wr(0, mk(1, 3, 1, 17, 1, 0), mk(0, 3, 2, 40, 0, 1));
    look_int = 1; look_reg = 3; #1;
    chk("R1 int3 vec", 32'(look_vec), 1);
    chk("R4 int3 tgt", 32'(look_tgt), 17);
    look_int = 0; #1;
    chk("R4 fp3 vec flag clear", 32'(look_vec), 0);
    chk("R4 fp3 packed", 32'(look_packed), 1);
    chk("R4 fp3 ew", 32'(look_ew), 2);
    sweep("R1 pair load");
  endtask

  task automatic t_wipe; // R2
    cfg_wr(1, mk(1, 8, 3, 5, 1, 1), mk(1, 9, 0, 6, 1, 0));
    cfg_wr(2, mk(0, 20, 1, 7, 1, 0), mk(0, 21, 1, 8, 1, 0));
    look_int = 0; look_reg = 21; #1;
    chk("R2 fp21 before wipe", 32'(look_vec), 1);
    cfg_wr(1, mk(1, 8, 3, 5, 1, 1), mk(1, 10, 0, 2, 1, 0));
    look_int = 0; look_reg = 21; #1;
    chk("R2 fp21 wiped", 32'(look_vec), 0);
    look_int = 1; look_reg = 3; #1;
    chk("R2 entry below kept", 32'(look_vec), 1);
    sweep("R2 wipe");
  endtask

  task automatic t_stop; // R3
    cfg_wr(0, 16'h0000, mk(1, 12, 1, 9, 1, 0));
    look_int = 1; look_reg = 12; #1;
    chk("R3 after zero head", 32'(look_vec), 0);
    cfg_wr(0, mk(1, 1, 1, 1, 1, 0), 16'h0000);
    csr_wr(1, {mk(1, 2, 1, 2, 1, 0), mk(1, 4, 1, 4, 1, 0)});
    mdl[2] = mk(1, 4, 1, 4, 1, 0); mdl[3] = mk(1, 2, 1, 2, 1, 0);
    look_int = 1; look_reg = 4; #1;
    chk("R3 beyond zero gap", 32'(look_vec), 0);
    look_reg = 1; #1;
    chk("R3 before gap", 32'(look_vec), 1);
    sweep("R3 stop");
  endtask

  task automatic t_override; // R5
    cfg_wr(0, mk(1, 7, 1, 11, 1, 0), mk(1, 7, 3, 33, 0, 1));
    look_int = 1; look_reg = 7; #1;
    chk("R5 later wins vec", 32'(look_vec), 0);
    chk("R5 later wins tgt", 32'(look_tgt), 33);
    cfg_wr(0, mk(1, 7, 1, 11, 1, 0), mk(1, 7, 2, 12, 1, 0));
    look_int = 1; look_reg = 7; #1;
    chk("R5 vec set", 32'(look_vec), 1);
    look_int = 0; #1;
    chk("R5 other class", 32'(look_vec), 0);
    sweep("R5 override");
  endtask

  task automatic t_clear; // R6
    cfg_wr(0, mk(0, 30, 1, 3, 1, 1), mk(0, 31, 1, 4, 1, 0));
    look_int = 1; look_reg = 7; #1;
    chk("R6 old slot cleared tgt", 32'(look_tgt), 0);
    chk("R6 old slot cleared vec", 32'(look_vec), 0);
    look_int = 0; look_reg = 31; #1;
    chk("R6 new slot next cycle", 32'(look_vec), 1);
    sweep("R6 clear");
  endtask

  task automatic t_len; // R7 R8
    csr_wr(8, 32'd100);
    chk("R7 mvl clamp", 32'(mvl), 63);
    csr_wr(8, 32'd63);
    chk("R7 mvl at cap", 32'(mvl), 63);
    csr_wr(9, 32'd50);
    chk("R8 vl under mvl", 32'(vl), 50);
    csr_wr(8, 32'd10);
    chk("R7 mvl small", 32'(mvl), 10);
    csr_wr(9, 32'h8000_0005);
    chk("R8 vl clamp", 32'(vl), 10);
    csr_wr(9, 32'd7);
    chk("R8 vl below", 32'(vl), 7);
  endtask

  task automatic t_read; // R9
    for (int a = 0; a < 8; a++) rd("R9 cfg read", a, 0);
    rd("R9 mvl read", 8, 10);
    rd("R9 vl read", 9, 7);
    rd("R9 unmapped read", 12, 0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #23 rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_pair_load();
    t_wipe();
    t_stop();
    t_override();
    t_clear();
    t_len();
    t_read();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule